// File: doc/BRIEF.md
# Double-Buffered Bulk-IN Endpoint Buffer

This block is the transmit buffer of one USB bulk IN endpoint. It has two banks of 64 bytes. A CPU or a DMA engine writes packet bytes into the bank on the write side. The serial interface engine (SIE) reads the other bank toward the host. The two banks trade roles, called a swap, only when both of these hold:

- the write-side bank is complete, meaning it is full or firmware has marked the end of the packet;
- the read-side bank holds nothing left to send.

Every swap raises a transmit-enable flag. While that flag is low, IN tokens get a NAK. The read-side data is kept until the host acknowledges it, so a failed transfer can be sent again from the first byte.

A DMA request line asks for bytes whenever the write side has room. It drops when the bank fills and returns as soon as a swap frees the bank. A terminal-count strobe masks it until firmware unmasks it. A full bank written by DMA swaps on its own only when auto-toggle is enabled. Otherwise it waits for the end-of-packet command.

Top module: `usb_bulk_in_pingpong`

## Requirements
- R1: After reset, `tx_en` is 0, `sie_count` is 0, `wr_ready` is 1 and `dma_req` is 0 while `dma_en` is 0.
- R2: When CPU writes (with `wr_is_dma`=0) fill the write bank to 64 bytes and the read side is empty, the bank is full one edge after the last write. The swap follows on the next edge: `sie_count` becomes 64, `tx_en` becomes 1 and `wr_ready` returns to 1.
- R3: While the read side holds unacknowledged data, a complete write bank does not swap. In that state `wr_ready` stays 0 and `sie_count` is unchanged. The swap happens on the edge after `sie_ack` empties the read side.
- R4: A bank filled by DMA writes (`wr_is_dma`=1) does not swap while `auto_toggle_en` is 0, until `eop_cmd` is given. With `auto_toggle_en`=1 it swaps as soon as it is full.
- R5: `eop_cmd` after a partial fill of N bytes causes a swap on the following edge. Afterwards `sie_count` is N and `tx_en` is 1.
- R6: `eop_cmd` with an empty write bank swaps in an empty packet. `sie_count` stays 0, `tx_en` becomes 1, and an `in_token` then gives `reply_zlp`=1 and `reply_nak`=0.
- R7: `reply_nak` is 1 during `in_token` whenever `tx_en` is 0, or the read side has neither bytes nor a pending empty packet.
- R8: `sie_data` presents the read-side bytes in write order and advances on each `sie_rd`. `sie_retry` rewinds it to the first byte. `sie_ack` sets `sie_count` to 0.
- R9: `dma_req` equals `dma_en` AND not masked AND `wr_ready`, combinationally. It therefore rises at once when DMA is enabled, falls when the bank is full, and rises again after the swap.
- R10: A `dma_tc` pulse holds `dma_req` at 0 from the next edge until a `dma_unmask` pulse.
- R11: `buf_clear` empties both banks, drops a pending end-of-packet and clears `tx_en` on the next edge.
- R12: An acknowledge that empties the read side clears `tx_en` until the next swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_data | input | DATA_W | Byte to write |
| wr_is_dma | input | 1 | Write comes from the DMA engine |
| wr_ready | output | 1 | Write bank can accept a byte |
| eop_cmd | input | 1 | End-of-packet command pulse |
| auto_toggle_en | input | 1 | Allow a full DMA-filled bank to swap by itself |
| buf_clear | input | 1 | Empty both banks |
| dma_en | input | 1 | DMA requests enabled |
| dma_tc | input | 1 | DMA terminal-count strobe (masks the request) |
| dma_unmask | input | 1 | Firmware unmask of the DMA request |
| dma_req | output | 1 | DMA request |
| sie_rd | input | 1 | SIE takes the current byte |
| sie_data | output | DATA_W | Current read-side byte |
| sie_count | output | $clog2(BANK_BYTES+1) | Bytes held in the read-side bank |
| sie_ack | input | 1 | Host acknowledged the packet |
| sie_retry | input | 1 | Timeout or no acknowledge; resend |
| in_token | input | 1 | IN token received |
| reply_nak | output | 1 | Answer the token with NAK |
| reply_zlp | output | 1 | Answer the token with an empty packet |
| tx_en | output | 1 | Transmit enabled (no forced NAK) |

## Verification
A wrong bank-select or count register shows up at the ports within one edge of the next swap. `sie_count` would read a wrong length, or `sie_data` would return bytes of the other packet. A stuck completion or empty-side condition shows as a missing or early swap. The bench observes it directly through `sie_count`, `tx_en` and `wr_ready` on the edge after the triggering write, end-of-packet or acknowledge. Mask and request errors appear combinationally on `dma_req` in the same cycle as the input that should change it.

// File: rtl/usb_bulk_in_pingpong.sv
module usb_bulk_in_pingpong #(
  parameter int DATA_W     = 8,
  parameter int BANK_BYTES = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             wr_is_dma,
  output logic                             wr_ready,
  input  logic                             eop_cmd,
  input  logic                             auto_toggle_en,
  input  logic                             buf_clear,
  input  logic                             dma_en,
  input  logic                             dma_tc,
  input  logic                             dma_unmask,
  output logic                             dma_req,
  input  logic                             sie_rd,
  output logic [DATA_W-1:0]                sie_data,
  output logic [$clog2(BANK_BYTES+1)-1:0]  sie_count,
  input  logic                             sie_ack,
  input  logic                             sie_retry,
  input  logic                             in_token,
  output logic                             reply_nak,
  output logic                             reply_zlp,
  output logic                             tx_en
);
  localparam int AW = $clog2(BANK_BYTES);
  localparam int CW = $clog2(BANK_BYTES+1);
  localparam logic [CW-1:0] FULL = CW'(BANK_BYTES);

  logic [DATA_W-1:0] mem [0:2*BANK_BYTES-1];
  logic          cpu_sel, eop_pend, last_dma, sie_zlp, dma_mask;
  logic [CW-1:0] cpu_cnt, sie_cnt, sie_ptr;

  logic cpu_full, cpu_done, sie_busy, swap, wr_fire, ack_fire, rd_fire;

  assign cpu_full = (cpu_cnt == FULL);
  assign cpu_done = eop_pend | (cpu_full & (~last_dma | auto_toggle_en));
  assign sie_busy = (sie_cnt != '0) | sie_zlp;
  assign swap     = cpu_done & ~sie_busy & ~buf_clear;
  assign wr_ready = ~cpu_full & ~eop_pend;
  assign wr_fire  = wr_valid & wr_ready & ~buf_clear;
  assign ack_fire = sie_ack & sie_busy & ~buf_clear;
  assign rd_fire  = sie_rd & (sie_ptr < sie_cnt);

  assign dma_req   = dma_en & ~dma_mask & wr_ready;
  assign sie_count = sie_cnt;
  assign sie_data  = mem[{~cpu_sel, sie_ptr[AW-1:0]}];
  assign reply_nak = in_token & (~tx_en | ~sie_busy);
  assign reply_zlp = in_token & tx_en & sie_zlp;

  always_ff @(posedge clk)
    if (wr_fire) mem[{cpu_sel, cpu_cnt[AW-1:0]}] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_sel  <= 1'b0;
      cpu_cnt  <= '0;
      eop_pend <= 1'b0;
      last_dma <= 1'b0;
      sie_cnt  <= '0;
      sie_ptr  <= '0;
      sie_zlp  <= 1'b0;
      tx_en    <= 1'b0;
    end else if (buf_clear) begin
      cpu_cnt  <= '0;
      eop_pend <= 1'b0;
      last_dma <= 1'b0;
      sie_cnt  <= '0;
      sie_ptr  <= '0;
      sie_zlp  <= 1'b0;
      tx_en    <= 1'b0;
    end else begin
      if (wr_fire) begin
        cpu_cnt  <= cpu_cnt + 1'b1;
        last_dma <= wr_is_dma;
      end
      if (eop_cmd) eop_pend <= 1'b1;
      if (swap) begin
        cpu_sel  <= ~cpu_sel;
        cpu_cnt  <= '0;
        eop_pend <= 1'b0;
        last_dma <= 1'b0;
        sie_cnt  <= cpu_cnt;
        sie_ptr  <= '0;
        sie_zlp  <= (cpu_cnt == '0);
        tx_en    <= 1'b1;
      end else if (ack_fire) begin
        sie_cnt  <= '0;
        sie_ptr  <= '0;
        sie_zlp  <= 1'b0;
        tx_en    <= 1'b0;
      end else if (sie_retry) begin
        sie_ptr  <= '0;
      end else if (rd_fire) begin
        sie_ptr  <= sie_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          dma_mask <= 1'b0;
    else if (dma_tc)     dma_mask <= 1'b1;
    else if (dma_unmask) dma_mask <= 1'b0;
  end

  p_swap_sets_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_cnt != '0 && $past(sie_cnt) == '0) |-> tx_en);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_cnt <= FULL) && (sie_cnt <= FULL));
  p_hold_sie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_cnt != '0 && !sie_ack && !buf_clear) |=> (sie_cnt == $past(sie_cnt)));
  p_nak_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_token && !tx_en) |-> reply_nak);
  p_no_req_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !dma_req);
  p_tc_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tc |=> !dma_req);
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |=> (!tx_en && sie_count == '0));
  p_ack_drops_tx_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_ack && sie_busy && !buf_clear) |=> !tx_en);
endmodule

// File: tb/usb_bulk_in_pingpong_bench.sv
`timescale 1ns/100ps
module usb_bulk_in_pingpong_bench;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_is_dma = 0, eop_cmd = 0, auto_toggle_en = 0, buf_clear = 0;
  logic dma_en = 0, dma_tc = 0, dma_unmask = 0, sie_rd = 0, sie_ack = 0, sie_retry = 0, in_token = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, dma_req, reply_nak, reply_zlp, tx_en;
  logic [7:0] sie_data;
  logic [6:0] sie_count;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_bulk_in_pingpong u_usb_bulk_in_pingpong (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_is_dma(wr_is_dma),
    .wr_ready(wr_ready), .eop_cmd(eop_cmd), .auto_toggle_en(auto_toggle_en), .buf_clear(buf_clear),
    .dma_en(dma_en), .dma_tc(dma_tc), .dma_unmask(dma_unmask), .dma_req(dma_req),
    .sie_rd(sie_rd), .sie_data(sie_data), .sie_count(sie_count), .sie_ack(sie_ack),
    .sie_retry(sie_retry), .in_token(in_token), .reply_nak(reply_nak), .reply_zlp(reply_zlp),
    .tx_en(tx_en));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic write_bytes(input int n, input int base, input bit dma);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_is_dma = dma; wr_data = 8'(base + 3*i);
      step();
    end
    wr_valid = 0; wr_is_dma = 0;
  endtask

  task automatic pulse_eop();  eop_cmd = 1;  step(); eop_cmd = 0;  endtask
  task automatic pulse_ack();  sie_ack = 1;  step(); sie_ack = 0;  endtask

  task automatic t_reset();
    chk("R1 tx_en", tx_en, 0);
    chk("R1 sie_count", sie_count, 0);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 dma_req", dma_req, 0);
    in_token = 1; #0.5;
    chk("R7 nak when off", reply_nak, 1);
    in_token = 0;
  endtask

  task automatic t_cpu_fill();
    write_bytes(64, 1, 0);
    chk("R2 wr_ready full", wr_ready, 0);
    chk("R2 no swap yet", sie_count, 0);
    step();
    chk("R2 sie_count", sie_count, 64);
    chk("R2 tx_en", tx_en, 1);
    chk("R2 wr_ready back", wr_ready, 1);
    in_token = 1; #0.5;
    chk("R7 no nak when data", reply_nak, 0);
    in_token = 0;
    for (int i = 0; i < 3; i++) begin
      sie_rd = 1; #0.5;
      chk("R8 byte order", sie_data, 1 + 3*i);
      step();
    end
    sie_rd = 0;
    sie_retry = 1; step(); sie_retry = 0;
    chk("R8 retry rewinds", sie_data, 1);
  endtask

  task automatic t_blocked_swap();
    write_bytes(64, 100, 0);
    step(3);
    chk("R3 wr_ready held", wr_ready, 0);
    chk("R3 sie_count held", sie_count, 64);
    chk("R3 old data kept", sie_data, 1);
    pulse_ack();
    chk("R8 ack empties", sie_count, 0);
    chk("R12 tx_en cleared", tx_en, 0);
    step();
    chk("R3 swap after ack", sie_count, 64);
    chk("R3 tx_en", tx_en, 1);
    chk("R3 new data", sie_data, 100);
    pulse_ack();
    step(2);
    chk("R12 tx_en stays off", tx_en, 0);
    in_token = 1; #0.5;
    chk("R7 nak after ack", reply_nak, 1);
    in_token = 0;
  endtask

  task automatic t_dma();
    dma_en = 1; #0.5;
    chk("R9 immediate req", dma_req, 1);
    auto_toggle_en = 0;
    write_bytes(64, 7, 1);
    chk("R9 req drops full", dma_req, 0);
    step(3);
    chk("R4 no auto swap", sie_count, 0);
    pulse_eop();
    chk("R4 swap pending", sie_count, 0);
    step();
    chk("R4 swap by eop", sie_count, 64);
    chk("R9 req back", dma_req, 1);
    pulse_ack();
    auto_toggle_en = 1;
    write_bytes(64, 9, 1);
    step();
    chk("R4 auto swap", sie_count, 64);
    chk("R4 data", sie_data, 9);
    pulse_ack();
    auto_toggle_en = 0;
    dma_tc = 1; step(); dma_tc = 0;
    chk("R10 masked", dma_req, 0);
    step(2);
    chk("R10 still masked", dma_req, 0);
    dma_unmask = 1; step(); dma_unmask = 0;
    chk("R10 unmasked", dma_req, 1);
    dma_en = 0;
  endtask

  task automatic t_short_and_zlp();
    write_bytes(5, 40, 0);
    pulse_eop(); step();
    chk("R5 short count", sie_count, 5);
    chk("R5 tx_en", tx_en, 1);
    chk("R5 first byte", sie_data, 40);
    pulse_ack();
    pulse_eop(); step();
    chk("R6 zlp count", sie_count, 0);
    chk("R6 tx_en", tx_en, 1);
    in_token = 1; #0.5;
    chk("R6 reply_zlp", reply_zlp, 1);
    chk("R6 no nak", reply_nak, 0);
    in_token = 0;
    pulse_ack();
    in_token = 1; #0.5;
    chk("R6 zlp gone", reply_zlp, 0);
    chk("R7 nak", reply_nak, 1);
    in_token = 0;
  endtask

  task automatic t_clear();
    write_bytes(64, 2, 0);
    step();
    write_bytes(3, 50, 0);
    pulse_eop();
    buf_clear = 1; step(); buf_clear = 0;
    chk("R11 sie_count", sie_count, 0);
    chk("R11 tx_en", tx_en, 0);
    chk("R11 wr_ready", wr_ready, 1);
    step(2);
    chk("R11 eop dropped", sie_count, 0);
    write_bytes(1, 77, 0);
    pulse_eop(); step();
    chk("R11 write bank emptied", sie_count, 1);
    chk("R11 data", sie_data, 77);
    pulse_ack();
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    t_reset();
    t_cpu_fill();
    t_blocked_swap();
    t_dma();
    t_short_and_zlp();
    t_clear();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule